// File: doc/BRIEF.md
# MDIO Management Frame Master

This block drives the two-wire PHY management bus (MDC clock, bidirectional MDIO data) from a single 32-bit command word. Software writes a word that names a PHY, a register inside that PHY, and a read or write request, with 16 data bits for a write. The block then clocks out one complete management frame. MDC is derived from the system clock by a parameterised half-period divider. MDIO is presented as a data output plus an output enable, and the pad tri-state is built outside the block.

For a read, the block releases MDIO after the address fields and shifts in the 16 bits the PHY returns. It then raises a completion flag in the readable status word, next to the returned value. The status word mirrors the command layout, so software can poll the word it wrote and find the answer in the same place. While a frame is running, further command writes are dropped.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset and whenever no frame is running, MDC is low and the MDIO output enable is low. After reset the status word reads zero.
- R2: Every frame starts with PREAMBLE_LEN (default 35) consecutive driven one bits.
- R3: The preamble is followed by the start pair 0,1 and then the opcode pair: 1,0 for a read, 0,1 for a write.
- R4: The opcode is followed by the PHY address (command bits 25:21) and then the register number (command bits 20:16), each 5 bits, most significant bit first.
- R5: A write frame (command bit 26) continues with the driven turnaround pair 1,0 and then the 16 data bits from command bits 15:0, most significant first. The frame is PREAMBLE_LEN+32 bits long, and MDIO is driven for every bit.
- R6: A read frame (command bit 27) releases MDIO for one turnaround bit and then for 16 data bits. It samples the data most significant first at each MDC rising edge and is PREAMBLE_LEN+31 bits long. At its end, status bit 28 is set and status bits 15:0 hold the sampled value.
- R7: Each MDC low phase and high phase lasts exactly HALF_CYCLES system clocks. MDIO and its enable change only at an MDC falling edge and stay stable while MDC is high.
- R8: An accepted command clears status bit 28 on the following clock. From then on, status bits 27:16 show the effective operation (bit 27 read, bit 26 write), the PHY address and the register. For a write, bits 15:0 show the write data; for a read they show zero until the read completes.
- R9: A command written while a frame is running is ignored. The frame on the wire and the status word are unaffected.
- R10: A command word with both request bits set runs as a read. A word with neither request bit set, or with any of bits 31:28 set, is ignored: no frame starts and the status word keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command word, one cycle |
| cmd_wdata | input | 32 | Command word: bit 27 read, bit 26 write, 25:21 PHY, 20:16 register, 15:0 write data |
| status_rdata | output | 32 | Status word: bit 28 read done, 27:16 accepted command fields, 15:0 data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for the MDIO pad, high to drive |
| mdio_i | input | 1 | Management data sampled from the pad |

## Verification
The bench reconstructs every frame bit by bit at MDC rising edges and compares each field against the command word. An opcode pair emitted in the wrong order, an address shifted from the wrong end, or a read turnaround that keeps driving MDIO would each show up in its own section count. A model PHY answers reads with data such as 0x0001, 0xFFFF and 0x8001. Those values expose an off-by-one in the sampling window: it would drop the MSB or shift in the released turnaround bit. Directed cases fire a second command in the middle of a frame, send words with no request bit or with reserved bits set, and set both request bits. A design that restarted its sequencer, cleared the done flag or overwrote the echoed fields in these cases would be caught on the status port or on the wire.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } mdio_phase_e;

    // Field positions inside the command / status word
    localparam int BIT_DONE = 28;
    localparam int BIT_RD   = 27;
    localparam int BIT_WR   = 26;
    localparam int PHY_LSB  = 21;
    localparam int REG_LSB  = 16;

    // Request handed from the command decoder to the frame sequencer
    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } mdio_req_t;

    // Bits 28..0 of the readable status word
    typedef struct packed {
        logic        done;
        logic        rd;
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
    } mdio_stat_t;

endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
    parameter int HALF_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic half_end
);
    localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign half_end = run && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!run || half_end) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int PREAMBLE_LEN = 35
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_req_t   req,
    input  logic        half_end,
    input  logic        mdio_i,
    output logic        busy,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        rd_done,
    output logic [15:0] rd_data
);
    localparam int PW = $clog2(PREAMBLE_LEN + 33);
    localparam logic [PW-1:0] PRE      = PW'(PREAMBLE_LEN);
    localparam logic [PW-1:0] TA_POS   = PW'(PREAMBLE_LEN + 14);
    localparam logic [PW-1:0] RD_FIRST = PW'(PREAMBLE_LEN + 15);
    localparam logic [PW-1:0] RD_LAST  = PW'(PREAMBLE_LEN + 30);
    localparam logic [PW-1:0] WR_LAST  = PW'(PREAMBLE_LEN + 31);

    typedef struct packed {
        mdio_phase_e    phase;
        logic [PW-1:0]  pos;
        logic [31:0]    shreg;
        logic           is_rd;
        logic [15:0]    rdsh;
        logic           mdc;
        logic           mdo;
        logic           oe;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic       frame_end;

    always_comb begin
        logic [PW-1:0] pos_nx;
        logic [31:0]   sh_nx;
        logic [PW-1:0] last_pos;
        s_d       = s_q;
        frame_end = 1'b0;
        pos_nx    = s_q.pos + 1'b1;
        sh_nx     = s_q.shreg;
        last_pos  = s_q.is_rd ? RD_LAST : WR_LAST;
        case (s_q.phase)
            PH_IDLE: begin
                if (start) begin
                    s_d.phase = PH_LOW;
                    s_d.pos   = '0;
                    s_d.is_rd = req.rd;
                    s_d.rdsh  = '0;
                    s_d.mdc   = 1'b0;
                    s_d.mdo   = 1'b1;
                    s_d.oe    = 1'b1;
                    if (req.rd) s_d.shreg = {2'b01, 2'b10, req.phy, req.regad, 18'd0};
                    else        s_d.shreg = {2'b01, 2'b01, req.phy, req.regad, 2'b10, req.data};
                end
            end
            PH_LOW: begin
                if (half_end) begin
                    s_d.phase = PH_HIGH;
                    s_d.mdc   = 1'b1;
                    if (s_q.is_rd && s_q.pos >= RD_FIRST)
                        s_d.rdsh = {s_q.rdsh[14:0], mdio_i};
                end
            end
            PH_HIGH: begin
                if (half_end) begin
                    s_d.mdc = 1'b0;
                    if (s_q.pos == last_pos) begin
                        s_d.phase = PH_IDLE;
                        s_d.oe    = 1'b0;
                        s_d.mdo   = 1'b1;
                        frame_end = 1'b1;
                    end else begin
                        if (s_q.pos >= PRE) sh_nx = {s_q.shreg[30:0], 1'b0};
                        s_d.shreg = sh_nx;
                        s_d.pos   = pos_nx;
                        s_d.phase = PH_LOW;
                        s_d.mdo   = (pos_nx < PRE) ? 1'b1 : sh_nx[31];
                        s_d.oe    = !(s_q.is_rd && pos_nx >= TA_POS);
                    end
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
            s_q.mdo   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy    = (s_q.phase != PH_IDLE);
    assign mdc     = s_q.mdc;
    assign mdio_o  = s_q.mdo;
    assign mdio_oe = s_q.oe;
    assign rd_done = frame_end && s_q.is_rd;
    assign rd_data = s_q.rdsh;

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
    import mdio_pkg::*;
#(
    parameter int HALF_CYCLES  = 4,
    parameter int PREAMBLE_LEN = 35
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_wr,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] status_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic        seq_busy;
    logic        cmd_accept;
    logic        half_end;
    logic        rd_done;
    logic [15:0] rd_data;
    logic        req_rd, req_wr, rsvd_set;
    mdio_req_t   req;
    mdio_stat_t  st_d, st_q;

    assign req_rd   = cmd_wdata[BIT_RD];
    assign req_wr   = cmd_wdata[BIT_WR];
    assign rsvd_set = |cmd_wdata[31:28];

    assign cmd_accept = cmd_wr && !seq_busy && !rsvd_set && (req_rd || req_wr);

    assign req.rd    = req_rd;
    assign req.phy   = cmd_wdata[PHY_LSB +: 5];
    assign req.regad = cmd_wdata[REG_LSB +: 5];
    assign req.data  = cmd_wdata[15:0];

    always_comb begin
        st_d = st_q;
        if (cmd_accept) begin
            st_d.done  = 1'b0;
            st_d.rd    = req_rd;
            st_d.wr    = !req_rd;
            st_d.phy   = req.phy;
            st_d.regad = req.regad;
            st_d.data  = req_rd ? 16'd0 : req.data;
        end else if (rd_done) begin
            st_d.done = 1'b1;
            st_d.data = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_rdata = {3'b000, st_q};

    mdio_half_timer #(
        .HALF_CYCLES (HALF_CYCLES)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (seq_busy),
        .half_end (half_end)
    );

    mdio_frame_seq #(
        .PREAMBLE_LEN (PREAMBLE_LEN)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd_accept),
        .req      (req),
        .half_end (half_end),
        .mdio_i   (mdio_i),
        .busy     (seq_busy),
        .mdc      (mdc),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_done  (rd_done),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_wr,
    input logic        busy,
    input logic        accept,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        done,
    input logic [11:0] echo
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R7
    high_phase_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R6
    done_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> !$past(mdio_oe));

    // R8
    done_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !done);

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> $stable(echo));

endmodule

bind mdio_frame_master mdio_frame_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_wr  (cmd_wr),
    .busy    (seq_busy),
    .accept  (cmd_accept),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .done    (status_rdata[28]),
    .echo    (status_rdata[27:16])
);

// File: tb/mdio_frame_master_bench.sv
module mdio_frame_master_bench;
    localparam int HALF = 4;
    localparam int PRE  = 35;
    localparam int WAIT_FRAME = (PRE + 32) * 2 * HALF + 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wr = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] status_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // PHY model state
    logic        mdc_prev = 1'b0;
    logic        rec_bit [0:99];
    logic        rec_oe  [0:99];
    int          nrec = 0;
    logic [15:0] resp = '0;
    int          ph_len = 0;
    int          hi_len = 0;
    int          lo_len = 0;

    always #4 clk = ~clk;

    mdio_frame_master #(.HALF_CYCLES(HALF), .PREAMBLE_LEN(PRE)) u_mdio_frame_master (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .status_rdata(status_rdata), .mdc(mdc), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // Model PHY: records bits at MDC rise, drives read data after MDC fall
    always @(negedge clk) begin
        if (mdc && !mdc_prev) begin
            if (nrec < 100) begin
                rec_bit[nrec] = mdio_o;
                rec_oe[nrec]  = mdio_oe;
            end
            nrec   = nrec + 1;
            lo_len = ph_len;
            ph_len = 1;
        end else if (!mdc && mdc_prev) begin
            hi_len = ph_len;
            ph_len = 1;
            if (nrec >= PRE + 15 && nrec < PRE + 31)
                mdio_i = resp[15 - (nrec - PRE - 15)];
            else
                mdio_i = 1'b1;
        end else begin
            ph_len = ph_len + 1;
        end
        mdc_prev = mdc;
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
        end
    endtask

    task automatic exp_bit(input logic [31:0] cmd, input int idx, output logic b, output logic oe);
        logic        rd;
        logic [13:0] hdr;
        logic [17:0] tail;
        int k;
        rd   = cmd[27];
        hdr  = {2'b01, (rd ? 2'b10 : 2'b01), cmd[25:21], cmd[20:16]};
        tail = {2'b10, cmd[15:0]};
        b = 1'b1; oe = 1'b1;
        if (idx >= PRE) begin
            k = idx - PRE;
            if (k < 14) b = hdr[13 - k];
            else if (rd) begin b = 1'b0; oe = 1'b0; end
            else b = tail[17 - (k - 14)];
        end
    endtask

    task automatic issue(input logic [31:0] cmd);
        nrec = 0;
        @(negedge clk);
        cmd_wr = 1'b1;
        cmd_wdata = cmd;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic check_frame(input logic [31:0] cmd);
        int bad_pre = 0, bad_so = 0, bad_adr = 0, bad_tail = 0;
        int exp_len;
        logic rd;
        rd = cmd[27];
        exp_len = rd ? PRE + 31 : PRE + 32;
        for (int i = 0; i < exp_len && i < 100; i++) begin
            logic b, oe, mis;
            exp_bit(cmd, i, b, oe);
            mis = (rec_oe[i] !== oe) || (oe && rec_bit[i] !== b);
            if (mis) begin
                if (i < PRE) bad_pre++;
                else if (i < PRE + 4) bad_so++;
                else if (i < PRE + 14) bad_adr++;
                else bad_tail++;
            end
        end
        chk(bad_pre == 0, "R2 preamble", bad_pre, 0);
        chk(bad_so == 0, "R3 start/opcode", bad_so, 0);
        chk(bad_adr == 0, "R4 addresses", bad_adr, 0);
        if (rd) begin
            chk(bad_tail == 0, "R6 released tail", bad_tail, 0);
            chk(nrec == exp_len, "R6 read length", nrec, exp_len);
        end else begin
            chk(bad_tail == 0, "R5 write tail", bad_tail, 0);
            chk(nrec == exp_len, "R5 write length", nrec, exp_len);
        end
    endtask

    function automatic logic [31:0] exp_status(input logic [31:0] cmd, input logic [15:0] r, input bit fin);
        logic rd;
        rd = cmd[27];
        return {3'b000, (rd & fin), rd, !rd, cmd[25:21], cmd[20:16],
                (rd ? (fin ? r : 16'd0) : cmd[15:0])};
    endfunction

    // {command word, PHY read response}
    localparam logic [47:0] VECS [7] = '{
        48'h0420_8000_0000,
        48'h0862_0000_1234,
        48'h07FF_A5C3_0000,
        48'h0800_0000_FFFF,
        48'h0AAA_0000_0001,
        48'h0C44_1111_8001,
        48'h0401_0000_0000
    };

    initial begin
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(status_rdata == 32'd0, "R1 reset status", status_rdata, 0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 reset pins", {mdc, mdio_oe}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        foreach (VECS[v]) begin
            logic [31:0] c;
            c = VECS[v][47:16];
            resp = VECS[v][15:0];
            issue(c);
            // R8 done cleared and fields echoed right after acceptance
            chk(status_rdata == exp_status(c, resp, 1'b0), "R8 accept status",
                status_rdata, exp_status(c, resp, 1'b0));
            repeat (WAIT_FRAME) @(negedge clk);
            check_frame(c);
            // R6 / R10 final status (both-bit word runs as a read)
            chk(status_rdata == exp_status(c, resp, 1'b1), "R6 final status",
                status_rdata, exp_status(c, resp, 1'b1));
            // R1 idle after frame
            chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle pins", {mdc, mdio_oe}, 0);
        end

        // R7 half-period lengths measured on the last frame
        chk(hi_len == HALF, "R7 high phase", hi_len, HALF);
        chk(lo_len == HALF, "R7 low phase", lo_len, HALF);

        // R9 command during a frame is ignored
        resp = 16'hBEEF;
        issue(32'h0862_0000);
        repeat (100) @(negedge clk);
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = 32'h07FF_5555;
        @(negedge clk); cmd_wr = 1'b0;
        chk(status_rdata == exp_status(32'h0862_0000, resp, 1'b0), "R9 status mid-frame",
            status_rdata, exp_status(32'h0862_0000, resp, 1'b0));
        repeat (WAIT_FRAME) @(negedge clk);
        check_frame(32'h0862_0000);
        chk(status_rdata == exp_status(32'h0862_0000, resp, 1'b1), "R9 status after",
            status_rdata, exp_status(32'h0862_0000, resp, 1'b1));

        // R10 no request bit: ignored
        snap = status_rdata;
        issue(32'h0022_1234);
        repeat (60) @(negedge clk);
        chk(status_rdata == snap, "R10 no-request status", status_rdata, snap);
        chk(nrec == 0, "R10 no-request frame", nrec, 0);

        // R10 reserved bit set: ignored
        issue(32'h1422_1234);
        repeat (60) @(negedge clk);
        chk(status_rdata == snap, "R10 reserved status", status_rdata, snap);
        chk(nrec == 0, "R10 reserved frame", nrec, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule